// File: doc/BRIEF.md
# Splittable Output-Compare Timer

This block is a free-running up-counter paired with a compare register. It runs in one of two modes. In wide mode, one compare value as wide as the whole counter is checked against the whole counter. In split mode, counter and compare register each break into two independent byte-wide halves, and each half has its own comparison. Every compare channel keeps a match flag and an interrupt request flag. An enable bit gates the request out to an interrupt pin. Each channel also drives an output pin that flips on every match and can be forced to a chosen level by software.

Software reaches the block through a byte-wide register port with a synchronous, registered read. In wide mode, a shared holding byte makes the two halves move as one unit. On writes, the upper compare byte is parked in the holding byte and lands together with the lower byte. On reads, the lower counter byte is captured in the holding byte when the upper byte is read. A single count-enable input advances the counter by one per clock.

Register map (`addr`): 0 compare upper, 1 compare lower, 2 counter upper (read), 3 counter lower (read), 4 control, 5 status. Control bits: [0] split mode, [1] upper pin level, [2] lower pin level, [3] upper interrupt enable, [4] lower interrupt enable. A read of control returns the current pin states in bits [2:1]. Status bits: [4] upper match, [5] lower match, [6] upper request, [7] lower request.

Top module: `split_cmp_timer`

## Requirements
- R1: After reset both compare bytes read 0xFF, the counter reads 0, status reads 0, the mode is wide, and both output pins and both interrupt pins are 0.
- R2: In wide mode each enabled clock adds one to the full counter, with the lower byte carrying into the upper byte. When the counter steps onto the full compare value, status bits 4 and 6 are set.
- R3: In split mode both counter halves step on each enabled clock and each wraps from 0xFF to 0x00 on its own. The upper half stepping onto the upper compare byte sets bits 4 and 6. The lower half stepping onto the lower compare byte sets bits 5 and 7.
- R4: Each interrupt pin is high exactly when its request flag (status bit 6 or 7) and its enable bit (control bit 3 or 4) are both 1.
- R5: A match flips that channel's output pin. In wide mode the lower pin is never flipped.
- R6: A write to control sets the upper pin to bit 1 and the lower pin to bit 2. Later matches flip the pin starting from that level.
- R7: Status flags stay set until software writes 0 to their bit. Writing 1 leaves a flag unchanged. A match in the same cycle as a clearing write leaves the flag set.
- R8: With count-enable low, the counter holds and no match occurs, so the output pins do not flip again.
- R9: In wide mode a write to compare-upper changes only the holding byte, and a write to compare-lower commits the holding byte and the written byte together. In split mode each compare write goes straight to its byte.
- R10: In wide mode a read of counter-upper captures the lower counter byte, and the next read of counter-lower returns that captured byte. In split mode both counter reads are direct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Count enable, one step per clock |
| addr | input | 3 | Register select |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | HW | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_data | output | HW | Read data, valid the clock after rd_en |
| irq_hi | output | 1 | Upper / wide channel interrupt |
| irq_lo | output | 1 | Lower channel interrupt |
| out_hi | output | 1 | Upper / wide channel compare output |
| out_lo | output | 1 | Lower channel compare output |

## Verification
A corrupted counter or compare byte shows up as a match that comes too early, too late or never. The output pin then flips at the wrong step, and status read back one clock after the step shows the wrong flags. A stale holding byte shows up as a compare value or counter readback that is off in one byte on the next access. A flag that clears wrongly drops the interrupt pin at once, on the clock after the write. The bench counts exact step totals, including carries and independent half wraps, so any off-by-one shows up at the next status or pin sample.

// File: rtl/split_cmp_timer.sv
module split_cmp_timer #(
  parameter int HW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_en,
  input  logic [2:0]    addr,
  input  logic          wr_en,
  input  logic [HW-1:0] wr_data,
  input  logic          rd_en,
  output logic [HW-1:0] rd_data,
  output logic          irq_hi,
  output logic          irq_lo,
  output logic          out_hi,
  output logic          out_lo
);
  localparam logic [2:0] A_CMPH = 3'd0, A_CMPL = 3'd1, A_CNTH = 3'd2,
                         A_CNTL = 3'd3, A_CTRL = 3'd4, A_STAT = 3'd5;

  logic [HW-1:0] cmp_h, cmp_l, cnt_h, cnt_l, hold;
  logic          split, ien_h, ien_l;
  logic          fm_h, fm_l, fr_h, fr_l;

  wire wr_cmph = wr_en && addr == A_CMPH;
  wire wr_cmpl = wr_en && addr == A_CMPL;
  wire wr_ctrl = wr_en && addr == A_CTRL;
  wire wr_stat = wr_en && addr == A_STAT;

  wire [HW-1:0] nxt_l = cnt_l + 1'b1;
  wire [HW-1:0] nxt_h = cnt_h + ((split || &cnt_l) ? 1'b1 : 1'b0);

  wire hit_h = cnt_en && (split ? (nxt_h == cmp_h)
                                : ({nxt_h, nxt_l} == {cmp_h, cmp_l}));
  wire hit_l = cnt_en && split && (nxt_l == cmp_l);

  assign irq_hi = fr_h & ien_h;
  assign irq_lo = fr_l & ien_l;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_h <= '0;
      cnt_l <= '0;
    end else if (cnt_en) begin
      cnt_h <= nxt_h;
      cnt_l <= nxt_l;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_h <= '1;
      cmp_l <= '1;
      hold  <= '0;
    end else begin
      if (wr_cmph) begin
        if (split) cmp_h <= wr_data;
        else       hold  <= wr_data;
      end
      if (wr_cmpl) begin
        cmp_l <= wr_data;
        if (!split) cmp_h <= hold;
      end
      if (rd_en && addr == A_CNTH && !split) hold <= cnt_l;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      split <= 1'b0;
      ien_h <= 1'b0;
      ien_l <= 1'b0;
    end else if (wr_ctrl) begin
      split <= wr_data[0];
      ien_h <= wr_data[3];
      ien_l <= wr_data[4];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fm_h <= 1'b0;
      fm_l <= 1'b0;
      fr_h <= 1'b0;
      fr_l <= 1'b0;
    end else begin
      fm_h <= hit_h | (fm_h & ~(wr_stat & ~wr_data[4]));
      fm_l <= hit_l | (fm_l & ~(wr_stat & ~wr_data[5]));
      fr_h <= hit_h | (fr_h & ~(wr_stat & ~wr_data[6]));
      fr_l <= hit_l | (fr_l & ~(wr_stat & ~wr_data[7]));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_hi <= 1'b0;
      out_lo <= 1'b0;
    end else if (wr_ctrl) begin
      out_hi <= wr_data[1];
      out_lo <= wr_data[2];
    end else begin
      if (hit_h) out_hi <= ~out_hi;
      if (hit_l) out_lo <= ~out_lo;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_data <= '0;
    else if (rd_en) begin
      rd_data <= '0;
      case (addr)
        A_CMPH:  rd_data <= cmp_h;
        A_CMPL:  rd_data <= cmp_l;
        A_CNTH:  rd_data <= cnt_h;
        A_CNTL:  rd_data <= split ? cnt_l : hold;
        A_CTRL:  rd_data[4:0] <= {ien_l, ien_h, out_lo, out_hi, split};
        A_STAT:  rd_data[7:4] <= {fr_l, fr_h, fm_l, fm_h};
        default: rd_data <= '0;
      endcase
    end
  end

  AST_WIDE_MATCH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !split && {nxt_h, nxt_l} == {cmp_h, cmp_l}) |=> (fm_h && fr_h)); // R2
  AST_SPLIT_LO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && split && nxt_l == cmp_l) |=> (fm_l && fr_l)); // R3
  AST_HI_PIN_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_h && !wr_ctrl) |=> (out_hi != $past(out_hi))); // R5
  AST_LO_QUIET_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (!split && !wr_ctrl) |=> $stable(out_lo)); // R5
  AST_PINS_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !wr_ctrl) |=> ($stable(out_hi) && $stable(out_lo))); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_h && !wr_stat) |=> fr_h); // R7
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> ($stable(cnt_h) && $stable(cnt_l))); // R8
endmodule

// File: tb/test_split_cmp_timer.sv
module test_split_cmp_timer;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, cnt_en = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic irq_hi, irq_lo, out_hi, out_lo;

  split_cmp_timer #(.HW(8)) i_split_cmp_timer (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .irq_hi(irq_hi),
    .irq_lo(irq_lo), .out_hi(out_hi), .out_lo(out_lo));

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { int sel; logic [7:0] exp; string tag; } item_t;
  item_t q[$];
  int total = 0, bad = 0, cycles = 0;
  bit done = 0;

  task automatic push(int sel, logic [7:0] exp, string tag);
    item_t it;
    it.sel = sel; it.exp = exp; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, logic [7:0] exp, string tag);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    push(0, exp, tag);
  endtask

  task automatic pin(int sel, logic exp, string tag);
    @(negedge clk);
    push(sel, {7'b0, exp}, tag);
  endtask

  task automatic step(int n);
    @(negedge clk); cnt_en = 1'b1;
    repeat (n) @(negedge clk);
    cnt_en = 1'b0;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it = q.pop_front();
        case (it.sel)
          0: act = rd_data;
          1: act = {7'b0, out_hi};
          2: act = {7'b0, out_lo};
          3: act = {7'b0, irq_hi};
          default: act = {7'b0, irq_lo};
        endcase
        total++;
        if (act !== it.exp) begin
          bad++;
          $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 200000 && !done) begin
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected<=200000", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(3'd0, 8'hFF, "R1 cmp upper");
    rd(3'd1, 8'hFF, "R1 cmp lower");
    rd(3'd2, 8'h00, "R1 cnt upper");
    rd(3'd3, 8'h00, "R1 cnt lower");
    rd(3'd5, 8'h00, "R1 status");
    rd(3'd4, 8'h00, "R1 control");
    pin(1, 1'b0, "R1 out_hi"); pin(2, 1'b0, "R1 out_lo");
    pin(3, 1'b0, "R1 irq_hi"); pin(4, 1'b0, "R1 irq_lo");
    // R9 wide write through holding byte
    wr(3'd0, 8'h01);
    rd(3'd0, 8'hFF, "R9 upper held back");
    wr(3'd1, 8'h05);
    rd(3'd0, 8'h01, "R9 upper committed");
    rd(3'd1, 8'h05, "R9 lower committed");
    // R2 wide count with carry and match
    step(261);
    rd(3'd5, 8'h50, "R2 wide match flags");
    pin(1, 1'b1, "R5 out_hi flipped");
    pin(2, 1'b0, "R5 out_lo quiet in wide");
    pin(3, 1'b0, "R4 irq_hi disabled");
    rd(3'd2, 8'h01, "R10 cnt upper");
    rd(3'd3, 8'h05, "R10 cnt lower captured");
    // R4 enable, R6 forced level
    wr(3'd4, 8'h08);
    pin(1, 1'b0, "R6 level forced low");
    pin(3, 1'b1, "R4 irq_hi enabled");
    repeat (5) @(negedge clk);
    pin(1, 1'b0, "R8 no retoggle idle");
    // R7 selective clear
    wr(3'd5, 8'h40);
    rd(3'd5, 8'h40, "R7 write 1 keeps request");
    pin(3, 1'b1, "R4 irq_hi still set");
    wr(3'd5, 8'h00);
    rd(3'd5, 8'h00, "R7 write 0 clears");
    pin(3, 1'b0, "R4 irq_hi cleared");
    // R6 toggle from forced level
    wr(3'd4, 8'h02);
    pin(1, 1'b1, "R6 level forced high");
    wr(3'd0, 8'h01); wr(3'd1, 8'h08);
    step(3);
    pin(1, 1'b0, "R6 toggled from forced level");
    rd(3'd5, 8'h50, "R2 second match");
    // R7 match beats clear in same cycle
    wr(3'd5, 8'h00);
    wr(3'd0, 8'h01); wr(3'd1, 8'h0A);
    @(negedge clk); cnt_en = 1'b1;
    @(negedge clk); addr = 3'd5; wr_data = 8'h00; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; cnt_en = 1'b0;
    rd(3'd5, 8'h50, "R7 match wins over clear");
    pin(1, 1'b1, "R5 out_hi flipped again");
    // R3 split mode
    wr(3'd4, 8'h01);
    wr(3'd0, 8'h03);
    rd(3'd0, 8'h03, "R9 split direct upper");
    wr(3'd1, 8'h0C);
    wr(3'd5, 8'h00);
    step(2);
    rd(3'd5, 8'hF0, "R3 both halves match");
    pin(1, 1'b1, "R5 split out_hi");
    pin(2, 1'b1, "R5 split out_lo");
    wr(3'd5, 8'h00);
    wr(3'd0, 8'h00); wr(3'd1, 8'h02);
    step(246);
    rd(3'd5, 8'hA0, "R3 lower wraps alone");
    pin(2, 1'b0, "R5 out_lo flipped");
    pin(1, 1'b1, "R3 out_hi untouched");
    rd(3'd2, 8'hF9, "R10 split cnt upper");
    rd(3'd3, 8'h02, "R10 split cnt lower");
    wr(3'd4, 8'h11);
    pin(4, 1'b1, "R4 irq_lo enabled");
    pin(3, 1'b0, "R4 irq_hi no request");
    wr(3'd5, 8'h00);
    pin(4, 1'b0, "R4 irq_lo cleared");
    step(7);
    rd(3'd5, 8'h50, "R3 upper wraps to match");
    rd(3'd3, 8'h09, "R3 lower independent");
    pin(1, 1'b1, "R5 out_hi toggled from 0");
    repeat (3) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule